// File: doc/BRIEF.md
# Four-Character Command Mailbox

This block holds a command mailbox that a host fills over a parallel byte-wide register port. The mailbox has two parts. The first is a 4-byte command word that carries a four-character ASCII code. The second is a 64-byte data area for the command's arguments and results.

The host writes the four command bytes and then pulses a commit strobe. The block compares the word against a fixed list of fourteen codes. For a known code it issues a one-cycle dispatch pulse and a command index to the downstream engine, then holds the command until that engine reports completion. On completion the command word returns to zero. An unknown code is replaced by the error code `!CMD`. In both cases the host learns the outcome by reading the command word back.

Reads are combinational from a separate read address. Reserved addresses read as zero.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, all four command bytes and all 64 data bytes read as zero, and `dispatch_valid` is low.
- R2: Command byte k (k = 0..3) sits at address 0x00+k. The first character of a code is held in byte 0 (address 0x00), which is the least significant byte of the word, and the fourth character is held in byte 3.
- R3: When a commit occurs while no command is pending and the command word holds a known code, `dispatch_valid` is high for exactly one cycle, starting one clock after the commit. In that cycle `dispatch_idx` gives the code's position in this list: PBMs=0, PBMc=1, PBMe=2, GO2P=3, GSkC=4, GSrC=5, SSrC=6, SWDF=7, SWSk=8, SWSr=9, SWUF=10, DBfg=11, I2Cr=12, I2Cw=13.
- R4: Committing a non-zero word that is not in the list causes no dispatch, and one clock later the word reads back as `!CMD` (bytes 0x21, 0x43, 0x4D, 0x44 at addresses 0x00 to 0x03). Matching is exact and case-sensitive. A short code padded with spaces (0x20), such as "I2C ", is unknown. `!CMD` itself is unknown.
- R5: A `host_done` pulse while a command is pending clears the command word to zero one clock later and ends the pending state. A `host_done` while nothing is pending has no effect.
- R6: While a command is pending, host writes to command bytes and further commits are ignored. The word keeps its value and no second dispatch occurs.
- R7: Committing an all-zero command word causes no dispatch and leaves the word at zero. Each commit dispatches at most once.
- R8: Data bytes at 0x40 to 0x7F can be read and written at any time, including while a command is pending. Byte 0x40+n is byte n of the little-endian data area.
- R9: Reads of any address outside 0x00 to 0x03 and 0x40 to 0x7F return zero, and writes there change nothing.
- R10: A command-byte write and a commit in the same cycle decode the word with that byte already merged in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Byte write enable |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data byte |
| bus_commit | input | 1 | Commit strobe: decode the command word |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data byte (combinational) |
| host_done | input | 1 | Completion pulse from downstream engine |
| dispatch_valid | output | 1 | One-cycle dispatch pulse |
| dispatch_idx | output | 4 | Index of the dispatched code |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- **Near-miss codes.** The bench commits a lower-case variant, a space-padded short code and the error code itself. A decoder that is case-blind, ignores the padding, or treats `!CMD` as known would dispatch on these.
- **Pending state.** It writes and re-commits while a command is pending. A missing pending lock would corrupt the held word or dispatch twice.
- **Stray completion.** It pulses `host_done` while idle. A design that clears unconditionally would wipe a partly written command.
- **Zero word.** It commits an all-zero word. A careless design would turn it into `!CMD`.
- **Same-cycle write and commit.** It writes a command byte in the commit cycle. A decoder that looks at the stale register would miss the code.
- **Reserved addresses.** It writes reserved addresses. Leaky decode would alias those writes into the command or data bytes.

// File: rtl/cmd_mailbox_pkg.sv
// Package: code table and shared constants for the command mailbox.
// Assumes codes are stored first-character-in-least-significant-byte.
package cmd_mailbox_pkg;

    localparam int NUM_CODES = 14;
    localparam int IDX_W     = $clog2(NUM_CODES);
    localparam int CMD_BYTES = 4;

    // Reorder a text literal (first char in MSB) into storage order (first char in LSB).
    function automatic logic [31:0] to_store(input logic [31:0] text);
        return {text[7:0], text[15:8], text[23:16], text[31:24]};
    endfunction

    localparam logic [31:0] CODE_TABLE [NUM_CODES] = '{
        to_store("PBMs"), to_store("PBMc"), to_store("PBMe"), to_store("GO2P"),
        to_store("GSkC"), to_store("GSrC"), to_store("SSrC"), to_store("SWDF"),
        to_store("SWSk"), to_store("SWSr"), to_store("SWUF"), to_store("DBfg"),
        to_store("I2Cr"), to_store("I2Cw")
    };

    localparam logic [31:0] ERR_CODE = to_store("!CMD");

endpackage

// File: rtl/cmd_mailbox_decoder.sv
// Module: cmd_mailbox_decoder
// Compares a stored command word against every entry of the code table in
// parallel and reports a hit plus the index of the matching entry.
// Assumes table entries are unique, so at most one comparator fires.
module cmd_mailbox_decoder
    import cmd_mailbox_pkg::*;
(
    input  logic [31:0]      code,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [NUM_CODES-1:0] match;

    // One equality comparator per table entry.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
        assign match[i] = (code == CODE_TABLE[i]);
    end

    // Collapse the match vector to a hit flag and an encoded index.
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/cmd_mailbox_store.sv
// Module: cmd_mailbox_store
// Byte-wide data area with one write port and one combinational read port.
// Assumes the caller has already range-checked both indices.
module cmd_mailbox_store #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem [DEPTH];

    // Clear on reset, otherwise store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_byte;
        end
    end

    // Combinational read.
    assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/cmd_mailbox_ctrl.sv
// Module: cmd_mailbox_ctrl
// Owns the command word and the pending flag. It merges host byte writes,
// acts on commit using the decoder's verdict, and clears on completion.
// Assumes the decoder looks at cmd_merged, so a same-cycle write is seen.
module cmd_mailbox_ctrl
    import cmd_mailbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_lane,
    input  logic [7:0]       wr_byte,
    input  logic             commit,
    input  logic             done,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [31:0]      cmd_merged,
    output logic [31:0]      cmd_word,
    output logic             pending,
    output logic             disp_valid,
    output logic [IDX_W-1:0] disp_idx
);

    // Merge a host byte write into the word unless a command is locked in.
    always_comb begin
        cmd_merged = cmd_word;
        if (wr_en && !pending) cmd_merged[wr_lane*8 +: 8] = wr_byte;
    end

    // Command word, pending flag and dispatch pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word   <= '0;
            pending    <= 1'b0;
            disp_valid <= 1'b0;
            disp_idx   <= '0;
        end else begin
            disp_valid <= 1'b0;
            if (pending) begin
                if (done) begin
                    cmd_word <= '0;
                    pending  <= 1'b0;
                end
            end else if (commit && hit) begin
                cmd_word   <= cmd_merged;
                pending    <= 1'b1;
                disp_valid <= 1'b1;
                disp_idx   <= hit_idx;
            end else if (commit && (cmd_merged != '0)) begin
                cmd_word <= ERR_CODE;
            end else begin
                cmd_word <= cmd_merged;
            end
        end
    end

endmodule

// File: rtl/cmd_mailbox.sv
// Module: cmd_mailbox (top)
// Address decode for the byte port: command bytes, data area, reserved.
// Assumes the command and data windows do not overlap and fit in ADDR_W.
module cmd_mailbox
    import cmd_mailbox_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CMD_BASE   = 'h00,
    parameter int DATA_BASE  = 'h40,
    parameter int DATA_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic             host_done,
    output logic             dispatch_valid,
    output logic [IDX_W-1:0] dispatch_idx
);

    localparam int DAW = $clog2(DATA_BYTES);
    localparam logic [ADDR_W-1:0] CMD_LO  = ADDR_W'(CMD_BASE);
    localparam logic [ADDR_W-1:0] DATA_LO = ADDR_W'(DATA_BASE);
    localparam logic [ADDR_W-1:0] CMD_N   = ADDR_W'(CMD_BYTES);
    localparam logic [ADDR_W-1:0] DATA_N  = ADDR_W'(DATA_BYTES);

    logic [ADDR_W-1:0] wr_cmd_off, wr_dat_off, rd_cmd_off, rd_dat_off;
    logic              wr_in_cmd, wr_in_dat, rd_in_cmd, rd_in_dat;
    logic [31:0]       cmd_merged, cmd_value;
    logic              cmd_pending, dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    logic [7:0]        store_rd;

    // Window offsets and range checks for both ports.
    always_comb begin
        wr_cmd_off = bus_addr - CMD_LO;
        wr_dat_off = bus_addr - DATA_LO;
        rd_cmd_off = rd_addr - CMD_LO;
        rd_dat_off = rd_addr - DATA_LO;
        wr_in_cmd  = (wr_cmd_off < CMD_N);
        wr_in_dat  = (wr_dat_off < DATA_N);
        rd_in_cmd  = (rd_cmd_off < CMD_N);
        rd_in_dat  = (rd_dat_off < DATA_N);
    end

    cmd_mailbox_decoder u_dec (
        .code    (cmd_merged),
        .hit     (dec_hit),
        .hit_idx (dec_idx)
    );

    cmd_mailbox_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we && wr_in_cmd),
        .wr_lane    (wr_cmd_off[1:0]),
        .wr_byte    (bus_wdata),
        .commit     (bus_commit),
        .done       (host_done),
        .hit        (dec_hit),
        .hit_idx    (dec_idx),
        .cmd_merged (cmd_merged),
        .cmd_word   (cmd_value),
        .pending    (cmd_pending),
        .disp_valid (dispatch_valid),
        .disp_idx   (dispatch_idx)
    );

    cmd_mailbox_store #(.DEPTH(DATA_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && wr_in_dat),
        .wr_idx  (wr_dat_off[DAW-1:0]),
        .wr_byte (bus_wdata),
        .rd_idx  (rd_dat_off[DAW-1:0]),
        .rd_byte (store_rd)
    );

    // Read mux: command byte, data byte, or zero for reserved space.
    always_comb begin
        if (rd_in_cmd)      rd_data = cmd_value[rd_cmd_off[1:0]*8 +: 8];
        else if (rd_in_dat) rd_data = store_rd;
        else                rd_data = '0;
    end

endmodule

// File: rtl/cmd_mailbox_chk.sv
// Module: cmd_mailbox_chk
// Temporal checks on the mailbox, attached to every cmd_mailbox by bind.
// Assumes it sees the internal command word and pending flag of the top.
module cmd_mailbox_chk
    import cmd_mailbox_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_commit,
    input logic             host_done,
    input logic             dispatch_valid,
    input logic [IDX_W-1:0] dispatch_idx,
    input logic [31:0]      cmd_value,
    input logic             cmd_pending
);

    logic was_rst;

    // Word and pulse must be clear in the cycle after a reset edge.
    always_ff @(posedge clk) begin
        if (was_rst) begin
            assert_reset_clear_R1: assert (cmd_value == '0 && !dispatch_valid)
                else $error("R1 state not clear after reset");
        end
        was_rst <= !rst_n;
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |=> !dispatch_valid);

    assert_dispatch_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> ($past(bus_commit) && cmd_pending));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> (dispatch_idx < IDX_W'(NUM_CODES)));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && host_done) |=> (cmd_value == '0 && !cmd_pending));

    assert_hold_while_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && !host_done) |=> ($stable(cmd_value) && cmd_pending && !dispatch_valid));

endmodule

bind cmd_mailbox cmd_mailbox_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_commit     (bus_commit),
    .host_done      (host_done),
    .dispatch_valid (dispatch_valid),
    .dispatch_idx   (dispatch_idx),
    .cmd_value      (cmd_value),
    .cmd_pending    (cmd_pending)
);

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_commit = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       host_done = 1'b0;
    logic       dispatch_valid;
    logic [3:0] dispatch_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cmd_mailbox uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_commit(bus_commit), .rd_addr(rd_addr),
        .rd_data(rd_data), .host_done(host_done),
        .dispatch_valid(dispatch_valid), .dispatch_idx(dispatch_idx)
    );

    // Entry: {text (first char in MSB), expect dispatch, expected index}
    localparam int NV = 18;
    localparam logic [36:0] VEC [NV] = '{
        {"PBMs", 1'b1, 4'd0},  {"PBMc", 1'b1, 4'd1},  {"PBMe", 1'b1, 4'd2},
        {"GO2P", 1'b1, 4'd3},  {"GSkC", 1'b1, 4'd4},  {"GSrC", 1'b1, 4'd5},
        {"SSrC", 1'b1, 4'd6},  {"SWDF", 1'b1, 4'd7},  {"SWSk", 1'b1, 4'd8},
        {"SWSr", 1'b1, 4'd9},  {"SWUF", 1'b1, 4'd10}, {"DBfg", 1'b1, 4'd11},
        {"I2Cr", 1'b1, 4'd12}, {"I2Cw", 1'b1, 4'd13},
        {"I2C ", 1'b0, 4'd0},  {"pbms", 1'b0, 4'd0},  {"!CMD", 1'b0, 4'd0},
        {"GO2 ", 1'b0, 4'd0}
    };
    localparam logic [31:0] ERR_TXT = "!CMD";

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        bus_commit = 1'b1;
        @(negedge clk);
        bus_commit = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        host_done = 1'b1;
        @(negedge clk);
        host_done = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Assemble command bytes 0..3 into text order (byte 0 in MSB).
    task automatic read_cmd(output logic [31:0] w);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(8'(k), b);
            w[31-8*k -: 8] = b;
        end
    endtask

    task automatic write_cmd(input logic [31:0] t);
        for (int k = 0; k < 4; k++) wr(8'(k), t[31-8*k -: 8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_cmd(w);
        check("R1 cmd word", w, 32'h0);
        rd(8'h40, b); check("R1 data first", {24'h0, b}, 32'h0);
        rd(8'h7F, b); check("R1 data last", {24'h0, b}, 32'h0);
        check("R1 dispatch low", {31'h0, dispatch_valid}, 32'h0);

        // Table walk: R2, R3, R4, R5
        for (int v = 0; v < NV; v++) begin
            write_cmd(VEC[v][36:5]);
            rd(8'h00, b);
            check("R2 first char at byte 0", {24'h0, b}, {24'h0, VEC[v][36:29]});
            commit();
            check("R3/R4 dispatch flag", {31'h0, dispatch_valid}, {31'h0, VEC[v][4]});
            if (VEC[v][4]) begin
                check("R3 dispatch idx", {28'h0, dispatch_idx}, {28'h0, VEC[v][3:0]});
                @(negedge clk);
                check("R3 pulse one cycle", {31'h0, dispatch_valid}, 32'h0);
                read_cmd(w);
                check("R3 word held", w, VEC[v][36:5]);
                done_pulse();
                read_cmd(w);
                check("R5 cleared on done", w, 32'h0);
            end else begin
                read_cmd(w);
                check("R4 error code", w, ERR_TXT);
            end
        end

        // R6: writes and commits ignored while pending
        write_cmd("SWDF");
        commit();
        check("R6 first dispatch", {31'h0, dispatch_valid}, 32'h1);
        wr(8'h00, "X");
        commit();
        check("R6 no second dispatch", {31'h0, dispatch_valid}, 32'h0);
        read_cmd(w);
        check("R6 word unchanged", w, "SWDF");
        // R8: data writable while pending
        wr(8'h40, 8'hA5);
        wr(8'h7F, 8'h3C);
        rd(8'h40, b); check("R8 data 0x40", {24'h0, b}, 32'hA5);
        rd(8'h7F, b); check("R8 data 0x7F", {24'h0, b}, 32'h3C);
        done_pulse();
        read_cmd(w);
        check("R5 clear after pending", w, 32'h0);

        // R5: done while idle has no effect
        wr(8'h00, "D"); wr(8'h01, "B");
        done_pulse();
        read_cmd(w);
        check("R5 idle done ignored", w, {"DB", 16'h0});

        // R7: zero word commit
        write_cmd(32'h0);
        commit();
        check("R7 no dispatch on zero", {31'h0, dispatch_valid}, 32'h0);
        read_cmd(w);
        check("R7 stays zero", w, 32'h0);

        // R10: write and commit in the same cycle
        wr(8'h01, "2"); wr(8'h02, "C"); wr(8'h03, "w");
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = "I"; bus_commit = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_commit = 1'b0;
        check("R10 merged dispatch", {31'h0, dispatch_valid}, 32'h1);
        check("R10 merged idx", {28'h0, dispatch_idx}, 32'd13);
        done_pulse();

        // R9: reserved addresses
        wr(8'h10, 8'hFF);
        wr(8'h04, 8'h77);
        wr(8'h80, 8'h55);
        rd(8'h10, b); check("R9 reserved 0x10", {24'h0, b}, 32'h0);
        rd(8'h04, b); check("R9 reserved 0x04", {24'h0, b}, 32'h0);
        rd(8'h80, b); check("R9 reserved 0x80", {24'h0, b}, 32'h0);
        read_cmd(w);
        check("R9 cmd untouched", w, 32'h0);
        rd(8'h40, b); check("R9 data untouched", {24'h0, b}, 32'hA5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule